// File: doc/BRIEF.md
# Coherent RTC Time Reader

This block is a small bus master that pulls one self-consistent timestamp out of a battery-backed clock register file and hands it on as plain binary fields. A pulse on `start` launches a transaction. When `sync_en` is high, the reader first lines up with the clock's own once-a-second update: it polls the update flag until it sees it set, then polls until it sees it clear. When `sync_en` is low, it only polls until the flag reads clear. It then reads the seven time bytes and the mode byte, reads the seconds byte a second time, and starts over if the two seconds values differ.

The raw bytes are decoded under the mode byte: BCD or binary storage, and 12-hour or 24-hour format. The two-digit year is widened to a full four-digit year through a fixed window. The weekday and month are returned counted from zero. Each wait has a poll budget, and so does the number of consecutive seconds mismatches. Running out of any budget ends the transaction with `err` set.

Register reads go out on a valid/ready request channel and come back on a response strobe. At most one read is outstanding at a time. The request holds its address steady until it is accepted, so the register file can stall the reader for any number of cycles. The response may arrive any number of cycles after acceptance, and the response strobe has no ready, because the reader always waits for it.

Top module: `rtc_time_reader`

## Requirements
- R1: After reset `busy`, `done`, `err` and `rd_valid` are low, and no read is requested until `start` is seen.
- R2: With `sync_en` low, the reader reads address 10 until bit 7 of the returned byte is 0. It then reads addresses 0, 2, 4, 6, 7, 8, 9, 11 in that order, followed by address 0 again. Only one read is outstanding, and `rd_valid` with `rd_addr` holds steady until `rd_ready`.
- R3: With `sync_en` high, the reader reads address 10 until bit 7 is 1, then until bit 7 is 0, and starts the fetch of R2 straight after that, with no further flag read.
- R4: If bit 7 fails to become 1 within RISE_POLLS reads, or fails to become 0 within FALL_POLLS reads (in both the sync and non-sync flag waits), the transaction ends with `done` and `err` high.
- R5: If the second seconds read differs from the first, the reader goes back to the flag-clear wait of R2 and reads everything again. A mismatch that would be the (MAX_RETRY+1)th in a row ends the transaction with `err`. Exactly MAX_RETRY mismatches still succeed.
- R6: When bit 2 of the address-11 byte is 0, every field is BCD and is decoded as high nibble × 10 + low nibble. When that bit is 1, the fields are taken as binary.
- R7: Bit 7 of the hour byte is always removed before decoding. When bit 1 of the address-11 byte is 0 (12-hour mode) and hour bit 7 is set, 12 is added to the hour and a result of 24 becomes 0. When bit 1 is 1, bit 7 has no effect.
- R8: A decoded year of 69 to 99 gives 1969 to 1999, and a decoded year of 0 to 68 gives 2000 to 2068.
- R9: `t_wday` and `t_mon` are the decoded stored values minus one.
- R10: `done` is a one-cycle pulse with `busy` low. On success the fields change only in the `done` cycle. On failure they keep their old values. `err` is valid with `done` and stays set until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a read transaction (sampled while idle) |
| sync_en | input | 1 | Align to the update-flag edge before reading |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last transaction ran out of a poll or retry budget |
| rd_valid | output | 1 | Register read request valid |
| rd_ready | input | 1 | Register file accepts the request |
| rd_addr | output | 7 | Register address of the request |
| rsp_valid | input | 1 | Read data valid (one per accepted request) |
| rsp_data | input | 8 | Read data byte |
| t_sec | output | 8 | Seconds, binary |
| t_min | output | 8 | Minutes, binary |
| t_hour | output | 8 | Hour 0-23, binary |
| t_wday | output | 8 | Weekday counted from zero |
| t_mday | output | 8 | Day of month, binary |
| t_mon | output | 8 | Month counted from zero |
| t_year | output | 12 | Full year |

## Verification
The range assertions on hour, month and year rely on the register file holding legal time values for the selected mode: BCD digits no greater than 9, hours 0-23 or 1-12, months 1-12 and years 0-99. The register model in the bench only ever returns such values. The assertions also take for granted that `rsp_valid` comes only after an accepted request. The bench responder keeps to this by answering exactly once per handshake, after a configurable latency, while it optionally toggles `rd_ready` to exercise stalls.

// File: rtl/rtc_rd_pkg.sv
package rtc_rd_pkg;
  localparam int ADDR_W    = 7;
  localparam int DATA_W    = 8;
  localparam int YEAR_W    = 12;
  localparam int N_FETCH   = 8;
  localparam int IDX_W     = $clog2(N_FETCH);
  localparam int FLAG_ADDR = 10;
  localparam int FLAG_BIT  = 7;
  localparam int BIN_BIT   = 2;
  localparam int H24_BIT   = 1;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] byte_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RISE, ST_FALL, ST_GATE, ST_FETCH, ST_CHECK
  } rd_state_t;

  // Fetch order: seconds, minutes, hours, weekday, mday, month, year, mode
  function automatic addr_t fetch_addr(input logic [IDX_W-1:0] i);
    case (i)
      3'd0:    return addr_t'(0);
      3'd1:    return addr_t'(2);
      3'd2:    return addr_t'(4);
      3'd3:    return addr_t'(6);
      3'd4:    return addr_t'(7);
      3'd5:    return addr_t'(8);
      3'd6:    return addr_t'(9);
      default: return addr_t'(11);
    endcase
  endfunction

  function automatic byte_t bcd_to_bin(input byte_t b);
    return byte_t'(b[3:0]) + byte_t'(b[7:4]) * byte_t'(10);
  endfunction
endpackage

// File: rtl/rtc_rd_port.sv
module rtc_rd_port
  import rtc_rd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  go,
  input  addr_t go_addr,
  output logic  rd_valid,
  input  logic  rd_ready,
  output addr_t rd_addr,
  input  logic  rsp_valid,
  output logic  hit
);
  logic waiting;

  assign hit = waiting && rsp_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_addr  <= '0;
      waiting  <= 1'b0;
    end else begin
      if (rd_valid && rd_ready) begin
        rd_valid <= 1'b0;
        waiting  <= 1'b1;
      end
      if (hit) waiting <= 1'b0;
      if (go) begin
        rd_valid <= 1'b1;
        rd_addr  <= go_addr;
      end
    end
  end
endmodule

// File: rtl/rtc_rd_count.sv
module rtc_rd_count #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/rtc_rd_decode.sv
module rtc_rd_decode
  import rtc_rd_pkg::*;
(
  input  byte_t             raw_sec,
  input  byte_t             raw_min,
  input  byte_t             raw_hour,
  input  byte_t             raw_wday,
  input  byte_t             raw_mday,
  input  byte_t             raw_mon,
  input  byte_t             raw_year,
  input  logic              bin_mode,
  input  logic              h24_mode,
  output byte_t             f_sec,
  output byte_t             f_min,
  output byte_t             f_hour,
  output byte_t             f_wday,
  output byte_t             f_mday,
  output byte_t             f_mon,
  output logic [YEAR_W-1:0] f_year
);
  byte_t hv, yv;

  function automatic byte_t cv(input byte_t b, input logic bin);
    return bin ? b : bcd_to_bin(b);
  endfunction

  always_comb begin
    f_sec  = cv(raw_sec, bin_mode);
    f_min  = cv(raw_min, bin_mode);
    f_mday = cv(raw_mday, bin_mode);
    f_wday = cv(raw_wday, bin_mode) - byte_t'(1);
    f_mon  = cv(raw_mon, bin_mode) - byte_t'(1);

    hv = cv({1'b0, raw_hour[6:0]}, bin_mode);
    if (!h24_mode && raw_hour[7]) begin
      hv = hv + byte_t'(12);
      if (hv == byte_t'(24)) hv = '0;
    end
    f_hour = hv;

    yv = cv(raw_year, bin_mode);
    if (yv < byte_t'(69)) f_year = YEAR_W'(2000) + YEAR_W'(yv);
    else                  f_year = YEAR_W'(1900) + YEAR_W'(yv);
  end
endmodule

// File: rtl/rtc_time_reader.sv
module rtc_time_reader
  import rtc_rd_pkg::*;
#(
  parameter int RISE_POLLS = 1024,
  parameter int FALL_POLLS = 64,
  parameter int MAX_RETRY  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              sync_en,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  output logic [DATA_W-1:0] t_sec,
  output logic [DATA_W-1:0] t_min,
  output logic [DATA_W-1:0] t_hour,
  output logic [DATA_W-1:0] t_wday,
  output logic [DATA_W-1:0] t_mday,
  output logic [DATA_W-1:0] t_mon,
  output logic [YEAR_W-1:0] t_year
);
  localparam int PMAX = (RISE_POLLS > FALL_POLLS) ? RISE_POLLS : FALL_POLLS;
  localparam int PW   = $clog2(PMAX + 1);
  localparam int RW   = $clog2(MAX_RETRY + 2);

  rd_state_t          st, st_n;
  logic [IDX_W-1:0]   idx;
  byte_t              raw [N_FETCH];
  logic               go, hit;
  addr_t              go_addr;
  logic               poll_clr, poll_inc, rt_clr, rt_inc;
  logic               fin_ok, fin_bad;
  logic [PW-1:0]      poll_cnt;
  logic [RW-1:0]      rt_cnt;
  byte_t              d_sec, d_min, d_hour, d_wday, d_mday, d_mon;
  logic [YEAR_W-1:0]  d_year;

  assign busy = (st != ST_IDLE);

  rtc_rd_port u_port (
    .clk(clk), .rst_n(rst_n), .go(go), .go_addr(go_addr),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .hit(hit)
  );

  rtc_rd_count #(.W(PW)) u_poll (
    .clk(clk), .rst_n(rst_n), .clr(poll_clr), .inc(poll_inc), .cnt(poll_cnt)
  );

  rtc_rd_count #(.W(RW)) u_retry (
    .clk(clk), .rst_n(rst_n), .clr(rt_clr), .inc(rt_inc), .cnt(rt_cnt)
  );

  rtc_rd_decode u_dec (
    .raw_sec(raw[0]), .raw_min(raw[1]), .raw_hour(raw[2]), .raw_wday(raw[3]),
    .raw_mday(raw[4]), .raw_mon(raw[5]), .raw_year(raw[6]),
    .bin_mode(raw[7][BIN_BIT]), .h24_mode(raw[7][H24_BIT]),
    .f_sec(d_sec), .f_min(d_min), .f_hour(d_hour), .f_wday(d_wday),
    .f_mday(d_mday), .f_mon(d_mon), .f_year(d_year)
  );

  always_comb begin
    st_n     = st;
    go       = 1'b0;
    go_addr  = addr_t'(FLAG_ADDR);
    poll_clr = 1'b0;
    poll_inc = 1'b0;
    rt_clr   = 1'b0;
    rt_inc   = 1'b0;
    fin_ok   = 1'b0;
    fin_bad  = 1'b0;
    case (st)
      ST_IDLE: if (start) begin
        poll_clr = 1'b1;
        rt_clr   = 1'b1;
        go       = 1'b1;
        st_n     = sync_en ? ST_RISE : ST_GATE;
      end
      ST_RISE: if (hit) begin
        if (rsp_data[FLAG_BIT]) begin
          st_n = ST_FALL; poll_clr = 1'b1; go = 1'b1;
        end else if (poll_cnt == PW'(RISE_POLLS - 1)) begin
          fin_bad = 1'b1;
        end else begin
          poll_inc = 1'b1; go = 1'b1;
        end
      end
      ST_FALL, ST_GATE: if (hit) begin
        if (!rsp_data[FLAG_BIT]) begin
          st_n = ST_FETCH; go = 1'b1; go_addr = fetch_addr('0);
        end else if (poll_cnt == PW'(FALL_POLLS - 1)) begin
          fin_bad = 1'b1;
        end else begin
          poll_inc = 1'b1; go = 1'b1;
        end
      end
      ST_FETCH: if (hit) begin
        go = 1'b1;
        if (idx == IDX_W'(N_FETCH - 1)) begin
          st_n = ST_CHECK; go_addr = fetch_addr('0);
        end else begin
          go_addr = fetch_addr(idx + IDX_W'(1));
        end
      end
      ST_CHECK: if (hit) begin
        if (rsp_data == raw[0]) begin
          fin_ok = 1'b1;
        end else if (rt_cnt == RW'(MAX_RETRY)) begin
          fin_bad = 1'b1;
        end else begin
          rt_inc = 1'b1; poll_clr = 1'b1; go = 1'b1; st_n = ST_GATE;
        end
      end
      default: st_n = ST_IDLE;
    endcase
    if (fin_ok || fin_bad) st_n = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      idx    <= '0;
      done   <= 1'b0;
      err    <= 1'b0;
      t_sec  <= '0; t_min  <= '0; t_hour <= '0; t_wday <= '0;
      t_mday <= '0; t_mon  <= '0; t_year <= '0;
      for (int i = 0; i < N_FETCH; i++) raw[i] <= '0;
    end else begin
      st   <= st_n;
      done <= fin_ok || fin_bad;
      if (st == ST_IDLE && start) err <= 1'b0;
      if (fin_bad) err <= 1'b1;
      if (st != ST_FETCH) idx <= '0;
      else if (hit) begin
        raw[idx] <= rsp_data;
        idx      <= idx + IDX_W'(1);
      end
      if (fin_ok) begin
        t_sec  <= d_sec;  t_min <= d_min;  t_hour <= d_hour;
        t_wday <= d_wday; t_mday <= d_mday; t_mon <= d_mon;
        t_year <= d_year;
      end
    end
  end
endmodule

// File: rtl/rtc_time_reader_chk.sv
module rtc_time_reader_chk
  import rtc_rd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] t_sec,
  input logic [DATA_W-1:0] t_min,
  input logic [DATA_W-1:0] t_hour,
  input logic [DATA_W-1:0] t_wday,
  input logic [DATA_W-1:0] t_mday,
  input logic [DATA_W-1:0] t_mon,
  input logic [YEAR_W-1:0] t_year
);
  a_r1_no_req_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_valid);

  a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r10_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  a_r10_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(t_sec) && $stable(t_min) && $stable(t_hour) &&
              $stable(t_wday) && $stable(t_mday) && $stable(t_mon) &&
              $stable(t_year));

  a_r7_hour_range: assert property (@(posedge clk) disable iff (!rst_n)
    done && !err |-> t_hour < 8'd24);

  a_r9_month_range: assert property (@(posedge clk) disable iff (!rst_n)
    done && !err |-> t_mon < 8'd12 && t_wday < 8'd7);

  a_r8_year_window: assert property (@(posedge clk) disable iff (!rst_n)
    done && !err |-> t_year >= 12'd1969 && t_year <= 12'd2068);
endmodule

bind rtc_time_reader rtc_time_reader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .err(err), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
  .t_sec(t_sec), .t_min(t_min), .t_hour(t_hour), .t_wday(t_wday),
  .t_mday(t_mday), .t_mon(t_mon), .t_year(t_year)
);

// File: tb/rtc_time_reader_tb.sv
module rtc_time_reader_tb;
  localparam int RISE = 6;
  localparam int FALL = 4;
  localparam int RETRY = 3;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, sync_en = 1'b0;
  logic busy, done, err, rd_valid;
  logic rd_ready = 1'b1, rsp_valid = 1'b0;
  logic [6:0] rd_addr;
  logic [7:0] rsp_data = 8'h00;
  logic [7:0] t_sec, t_min, t_hour, t_wday, t_mday, t_mon;
  logic [11:0] t_year;

  always #5 clk = ~clk;

  rtc_time_reader #(.RISE_POLLS(RISE), .FALL_POLLS(FALL), .MAX_RETRY(RETRY)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .sync_en(sync_en), .busy(busy),
    .done(done), .err(err), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_addr(rd_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .t_sec(t_sec), .t_min(t_min), .t_hour(t_hour), .t_wday(t_wday),
    .t_mday(t_mday), .t_mon(t_mon), .t_year(t_year)
  );

  int n_chk = 0, n_bad = 0;
  logic [7:0] regs [0:15];
  logic [7:0] a_seq [0:7];
  int a_len = 1, mm = 0, lat = 1, a_reads = 0, s_reads = 0, n_log = 0, cd = 0;
  bit bp = 0;
  int addr_log [0:63];
  logic [7:0] pend;
  int o_sec, o_min, o_hour, o_wday, o_mday, o_mon, o_year, o_err;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // register-file responder, acting on the falling edge
  always @(negedge clk) begin
    rsp_valid = 1'b0;
    if (!rst_n) cd = 0;
    else begin
      if (cd > 0) begin
        cd--;
        if (cd == 0) begin rsp_valid = 1'b1; rsp_data = pend; end
      end
      rd_ready = bp ? ~rd_ready : 1'b1;
      if (rd_valid && rd_ready) begin
        if (n_log < 64) addr_log[n_log] = int'(rd_addr);
        n_log++;
        if (rd_addr == 7'd10) begin
          pend = a_seq[(a_reads < a_len) ? a_reads : a_len - 1];
          a_reads++;
        end else if (rd_addr == 7'd0) begin
          pend = (s_reads < 2 * mm) ? ((s_reads % 2) ? 8'h11 : 8'h10) : regs[0];
          s_reads++;
        end else pend = regs[rd_addr[3:0]];
        cd = lat;
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic set_time(input logic [7:0] s, mi, h, wd, md, mo, y, mode);
    regs[0] = s; regs[2] = mi; regs[4] = h; regs[6] = wd;
    regs[7] = md; regs[8] = mo; regs[9] = y; regs[11] = mode;
  endtask

  task automatic set_flag(input int len, input logic [7:0] v0, v1, v2, v3, v4);
    a_seq[0] = v0; a_seq[1] = v1; a_seq[2] = v2; a_seq[3] = v3; a_seq[4] = v4;
    a_len = len;
  endtask

  task automatic run(input logic sy, input string req);
    int n;
    a_reads = 0; s_reads = 0; n_log = 0;
    @(negedge clk); sync_en = sy; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(req, "busy after start", int'(busy), 1);
    n = 0;
    while (!done && n < 3000) begin @(negedge clk); n++; end
    chk(req, "done reached", int'(done), 1);
    o_sec = t_sec; o_min = t_min; o_hour = t_hour; o_wday = t_wday;
    o_mday = t_mday; o_mon = t_mon; o_year = t_year; o_err = err;
    chk("R10", "busy low with done", int'(busy), 0);
    @(negedge clk);
    chk("R10", "done one cycle", int'(done), 0);
    chk("R10", "err held after done", int'(err), o_err);
  endtask

  task automatic chk_time(input string req, input int s, mi, h, wd, md, mo, y);
    chk(req, "err", o_err, 0);
    chk(req, "sec", o_sec, s);  chk(req, "min", o_min, mi);
    chk(req, "hour", o_hour, h); chk(req, "wday", o_wday, wd);
    chk(req, "mday", o_mday, md); chk(req, "mon", o_mon, mo);
    chk(req, "year", o_year, y);
  endtask

  task automatic chk_order(input string req, input int first);
    int exp [0:8];
    int bad = 0;
    exp = '{0, 2, 4, 6, 7, 8, 9, 11, 0};
    for (int i = 0; i < 9; i++) if (addr_log[first + i] != exp[i]) bad++;
    chk(req, "fetch order errors", bad, 0);
    chk(req, "total reads", n_log, first + 9);
  endtask

  task automatic t_reset;
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "done", int'(done), 0);
    chk("R1", "err", int'(err), 0);
    chk("R1", "rd_valid", int'(rd_valid), 0);
    repeat (3) @(negedge clk);
    chk("R1", "no request without start", n_log, 0);
  endtask

  task automatic t_bcd24;
    set_time(8'h45, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99, 8'h02);
    set_flag(1, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    run(1'b0, "R2");
    chk_time("R6", 45, 59, 23, 6, 30 + 1, 11, 1999);
    chk("R9", "flag reads", a_reads, 1);
    chk_order("R2", 1);
  endtask

  task automatic t_bin12;
    set_time(8'd59, 8'd0, 8'h8B, 8'd1, 8'd1, 8'd1, 8'd5, 8'h04);
    set_flag(1, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    run(1'b0, "R6");
    chk_time("R7", 59, 0, 23, 0, 1, 0, 2005);
  endtask

  task automatic t_bcd12;
    set_time(8'h00, 8'h30, 8'h92, 8'h02, 8'h15, 8'h06, 8'h68, 8'h00);
    run(1'b0, "R7");
    chk_time("R7", 0, 30, 0, 1, 15, 5, 2068);
    regs[4] = 8'h12; regs[9] = 8'h69;
    run(1'b0, "R8");
    chk_time("R8", 0, 30, 12, 1, 15, 5, 1969);
    regs[4] = 8'h81; regs[9] = 8'h00;
    run(1'b0, "R8");
    chk_time("R8", 0, 30, 13, 1, 15, 5, 2000);
    regs[4] = 8'h91; regs[11] = 8'h02;
    run(1'b0, "R7");
    chk_time("R7", 0, 30, 11, 1, 15, 5, 2000);
  endtask

  task automatic t_gate;
    set_time(8'h07, 8'h08, 8'h09, 8'h03, 8'h04, 8'h05, 8'h21, 8'h02);
    set_flag(3, 8'h80, 8'h80, 8'h00, 8'h00, 8'h00);
    run(1'b0, "R2");
    chk("R2", "flag reads before fetch", a_reads, 3);
    chk_order("R2", 3);
    chk_time("R2", 7, 8, 9, 2, 4, 4, 2021);
  endtask

  task automatic t_sync;
    set_flag(5, 8'h00, 8'h00, 8'h80, 8'h80, 8'h00);
    run(1'b1, "R3");
    chk("R3", "flag reads", a_reads, 5);
    chk_order("R3", 5);
    chk_time("R3", 7, 8, 9, 2, 4, 4, 2021);
  endtask

  task automatic t_timeouts;
    set_flag(1, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    run(1'b1, "R4");
    chk("R4", "rise timeout err", o_err, 1);
    chk("R4", "rise polls", a_reads, RISE);
    chk("R10", "hour kept on error", o_hour, 9);
    set_flag(1, 8'h80, 8'h00, 8'h00, 8'h00, 8'h00);
    run(1'b1, "R4");
    chk("R4", "fall timeout err", o_err, 1);
    chk("R4", "fall polls", a_reads, 1 + FALL);
    run(1'b0, "R4");
    chk("R4", "gate timeout err", o_err, 1);
    chk("R4", "gate polls", a_reads, FALL);
    chk("R10", "year kept on error", o_year, 2021);
  endtask

  task automatic t_retry;
    set_flag(1, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    mm = 1;
    run(1'b0, "R5");
    chk("R5", "err cleared by new run", o_err, 0);
    chk("R5", "seconds reads one retry", s_reads, 4);
    chk("R5", "flag reads one retry", a_reads, 2);
    chk("R5", "sec from clean attempt", o_sec, 7);
    mm = RETRY;
    run(1'b0, "R5");
    chk("R5", "err at retry limit", o_err, 0);
    chk("R5", "seconds reads at limit", s_reads, 2 * (RETRY + 1));
    mm = RETRY + 1;
    run(1'b0, "R5");
    chk("R5", "err beyond limit", o_err, 1);
    chk("R5", "seconds reads beyond limit", s_reads, 2 * (RETRY + 1));
    mm = 0;
  endtask

  task automatic t_backpressure;
    bp = 1; lat = 3;
    set_time(8'h45, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99, 8'h02);
    run(1'b0, "R2");
    chk_order("R2", 1);
    chk_time("R2", 45, 59, 23, 6, 31, 11, 1999);
    bp = 0; lat = 1;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) regs[i] = 8'h00;
    for (int i = 0; i < 8; i++) a_seq[i] = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bcd24();
    t_bin12();
    t_bcd12();
    t_gate();
    t_sync();
    t_timeouts();
    t_retry();
    t_backpressure();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule